// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block serialises a stereo pair of 16-bit two's-complement samples onto one data line. Each sample is sent most significant bit first, in a frame made of two halves of 32 bit periods each. A frame clock marks the halves: low selects the left half and high selects the right half. The left word is always sent in the first half of the frame and the right word in the second half. No configuration reverses this order. Serial data changes on the falling edge of the bit clock, so a receiver samples it on the rising edge.

Static inputs set the clocking role and the data placement. As clock master, the block divides its system clock to make the bit clock and the frame clock. As clock slave, it takes both clocks from outside, samples them with the system clock and follows their edges. The placement inputs select one of three layouts: left-justified, I2S-style with a one-bit MSB delay, or right-justified, where the least significant bit ends each half.

Samples arrive on two strobed inputs and are held in registers. At the start of every left half, the held pair is copied into the transmit words. A sample that arrives while a frame is being sent therefore goes out in the next frame.

Top module: `stereo_ser_tx`

## Requirements
- R1: With `cfg_rjust`=0 and `cfg_msb_dly`=0, a word's MSB goes out in bit slot 0 of its half (slot 0 is the period that starts at the frame-clock transition). Bits follow MSB first through slot 15, and slots 16 to 31 are low.
- R2: With `cfg_rjust`=0 and `cfg_msb_dly`=1, the MSB goes out in slot 1 and the LSB in slot 16. Slot 0 and slots 17 to 31 are low.
- R3: With `cfg_rjust`=1, the MSB goes out in slot 16 and the LSB in slot 31 (the last slot of the half). Slots 0 to 15 are low, and `cfg_msb_dly` has no effect.
- R4: The left word is sent while the frame clock is 0 and the right word while it is 1. Every frame begins with the left half.
- R5: As master (`cfg_master`=1), `bclk_o` toggles every DIV system clocks, so one bit period lasts 2*DIV clocks. Each half lasts 32 bit periods. `lrck_o` changes only in the clock in which `bclk_o` falls.
- R6: `sdata` changes only at a bit-clock falling edge. As master, it changes in the same system clock as the fall of `bclk_o`. As slave, it changes on the second system clock edge after `bclk_i` falls.
- R7: As slave, a half starts at a `bclk_i` falling edge at which `lrck_i` differs from its value at the previous falling edge. Slot numbering restarts at 0 there, and the slots of an incomplete right half seen after reset stay low.
- R8: A strobed sample is held until the next left half starts and is sent in that frame. A sample strobed during a frame does not change the frame in progress.
- R9: A synchronous reset sets `sdata` low from the next clock edge, `bclk_o` to 0 and `lrck_o` to 1. As master, the first half after reset is a left half, and it starts 2*DIV clocks after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_master | input | 1 | 1: generate the bit and frame clocks; 0: follow external clocks |
| cfg_rjust | input | 1 | 1: right-justified placement |
| cfg_msb_dly | input | 1 | 1: one-slot MSB delay (when not right-justified) |
| left_data | input | 16 | Left-channel sample, two's complement |
| left_vld | input | 1 | Strobe that captures `left_data` |
| right_data | input | 16 | Right-channel sample, two's complement |
| right_vld | input | 1 | Strobe that captures `right_data` |
| bclk_i | input | 1 | External bit clock (slave mode) |
| lrck_i | input | 1 | External frame clock, 0 = left (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode; 0 in slave mode) |
| lrck_o | output | 1 | Generated frame clock (master mode; 0 in slave mode) |
| sdata | output | 1 | Serial data |

## Verification
The bench covers words with extreme bit patterns: 0x8000, 0x7FFF, all ones, and a single low bit. A design that misplaces the window by one slot, or reverses the bit order, corrupts these words in ways the bench can see.

It sets `cfg_msb_dly` together with right-justified placement. A design that still applies the delay would push the LSB past the end of the half.

In one test a new sample arrives halfway through a left half. A design that loads samples directly, with no hold stage, would send a mixture of the old and new words.

Other tests start slave operation in the middle of a right half and assert reset while a frame is being sent. A design that sends the right channel first, or keeps driving stale bits, fails these tests.

// File: rtl/stx_pkg.sv
package stx_pkg;

    // Slot index of a word's MSB inside its half.
    function automatic int msb_slot(input logic rjust, input logic msb_dly,
                                    input int half_slots, input int word_w);
        if (rjust)
            return half_slots - word_w;
        else if (msb_dly)
            return 1;
        else
            return 0;
    endfunction

endpackage

// File: rtl/stx_timing.sv
module stx_timing #(
    parameter int DIV        = 2,
    parameter int HALF_SLOTS = 32,
    parameter int POS_W      = $clog2(HALF_SLOTS) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             master,
    input  logic             bclk_i,
    input  logic             lrck_i,
    output logic             tick,
    output logic             new_left,
    output logic [POS_W-1:0] pos_nx,
    output logic             side_nx,
    output logic             bclk_o,
    output logic             lrck_o
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(HALF_SLOTS - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bclk;
        logic             side;
        logic [POS_W-1:0] pos;
        logic             b1;
        logic             b2;
        logic             l1;
    } tstate_t;

    localparam tstate_t RST_S = '{cnt: '0, bclk: 1'b0, side: 1'b1,
                                  pos: LAST_POS, b1: 1'b0, b2: 1'b0, l1: 1'b0};

    tstate_t q, d;

    always_comb begin
        d    = q;
        tick = 1'b0;
        d.b1 = bclk_i;
        d.b2 = q.b1;
        d.l1 = lrck_i;
        if (master) begin
            if (q.cnt == LAST_CNT) begin
                d.cnt  = '0;
                d.bclk = ~q.bclk;
                tick   = q.bclk;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt  = '0;
            d.bclk = 1'b0;
            tick   = q.b2 & ~q.b1;
        end
        if (tick) begin
            if (master) begin
                if (q.pos == LAST_POS) begin
                    d.pos  = '0;
                    d.side = ~q.side;
                end else begin
                    d.pos = q.pos + 1'b1;
                end
            end else if (q.l1 != q.side) begin
                d.pos  = '0;
                d.side = q.l1;
            end else if (q.pos != '1) begin
                d.pos = q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RST_S;
        else     q <= d;
    end

    assign pos_nx   = d.pos;
    assign side_nx  = d.side;
    assign new_left = tick & ~d.side & (d.pos == '0);
    assign bclk_o   = master & q.bclk;
    assign lrck_o   = rst ? 1'b1 : (master & q.side);

    // R5
    frame_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (master && q.side != $past(q.side)) |-> ($past(q.bclk) && !q.bclk));

    // R5
    half_len_chk: assert property (@(posedge clk) disable iff (rst)
        master |-> (q.pos <= LAST_POS));

    // R7
    slave_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (!master && q.b2 && !q.b1 && q.l1 != q.side) |=> (q.pos == '0));

endmodule

// File: rtl/stx_slot_bit.sv
module stx_slot_bit #(
    parameter int WORD_W     = 16,
    parameter int HALF_SLOTS = 32,
    parameter int POS_W      = $clog2(HALF_SLOTS) + 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic [POS_W-1:0]  pos,
    input  logic              rjust,
    input  logic              msb_dly,
    output logic              bit_o
);
    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    int               first;
    int               rel;
    logic [IDX_W-1:0] idx;

    always_comb begin
        first = stx_pkg::msb_slot(rjust, msb_dly, HALF_SLOTS, WORD_W);
        rel   = int'(pos) - first;
        idx   = IDX_W'(WORD_W - 1 - rel);
        bit_o = 1'b0;
        if (rel >= 0 && rel < WORD_W)
            bit_o = word[idx];
    end
endmodule

// File: rtl/stx_framer.sv
module stx_framer #(
    parameter int WORD_W     = 16,
    parameter int HALF_SLOTS = 32,
    parameter int POS_W      = $clog2(HALF_SLOTS) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rjust,
    input  logic              msb_dly,
    input  logic [WORD_W-1:0] left_data,
    input  logic              left_vld,
    input  logic [WORD_W-1:0] right_data,
    input  logic              right_vld,
    input  logic              tick,
    input  logic              new_left,
    input  logic [POS_W-1:0]  pos_nx,
    input  logic              side_nx,
    output logic              sdata
);
    typedef struct packed {
        logic [WORD_W-1:0] hold_l;
        logic [WORD_W-1:0] hold_r;
        logic [WORD_W-1:0] cur_l;
        logic [WORD_W-1:0] cur_r;
        logic              sdata;
    } fstate_t;

    fstate_t           q, d;
    logic [WORD_W-1:0] word_sel;
    logic              slot_bit;

    assign word_sel = side_nx  ? q.cur_r :
                      new_left ? q.hold_l : q.cur_l;

    stx_slot_bit #(.WORD_W(WORD_W), .HALF_SLOTS(HALF_SLOTS), .POS_W(POS_W)) u_bit (
        .word    (word_sel),
        .pos     (pos_nx),
        .rjust   (rjust),
        .msb_dly (msb_dly),
        .bit_o   (slot_bit)
    );

    always_comb begin
        d = q;
        if (left_vld)  d.hold_l = left_data;
        if (right_vld) d.hold_r = right_data;
        if (new_left) begin
            d.cur_l = q.hold_l;
            d.cur_r = q.hold_r;
        end
        if (tick) d.sdata = slot_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign sdata = q.sdata;

    // R6
    sdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(q.sdata));

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !new_left |=> ($stable(q.cur_l) && $stable(q.cur_r)));

    // R3
    rj_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && rjust && pos_nx < POS_W'(HALF_SLOTS - WORD_W)) |=> !q.sdata);

    // R9
    reset_low_chk: assert property (@(posedge clk)
        rst |=> !q.sdata);

endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx #(
    parameter int WORD_W     = 16,
    parameter int HALF_SLOTS = 32,
    parameter int DIV        = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_master,
    input  logic              cfg_rjust,
    input  logic              cfg_msb_dly,
    input  logic [WORD_W-1:0] left_data,
    input  logic              left_vld,
    input  logic [WORD_W-1:0] right_data,
    input  logic              right_vld,
    input  logic              bclk_i,
    input  logic              lrck_i,
    output logic              bclk_o,
    output logic              lrck_o,
    output logic              sdata
);
    localparam int POS_W = $clog2(HALF_SLOTS) + 1;

    logic             tick;
    logic             new_left;
    logic [POS_W-1:0] pos_nx;
    logic             side_nx;

    stx_timing #(.DIV(DIV), .HALF_SLOTS(HALF_SLOTS), .POS_W(POS_W)) u_timing (
        .clk      (clk),
        .rst      (rst),
        .master   (cfg_master),
        .bclk_i   (bclk_i),
        .lrck_i   (lrck_i),
        .tick     (tick),
        .new_left (new_left),
        .pos_nx   (pos_nx),
        .side_nx  (side_nx),
        .bclk_o   (bclk_o),
        .lrck_o   (lrck_o)
    );

    stx_framer #(.WORD_W(WORD_W), .HALF_SLOTS(HALF_SLOTS), .POS_W(POS_W)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .rjust      (cfg_rjust),
        .msb_dly    (cfg_msb_dly),
        .left_data  (left_data),
        .left_vld   (left_vld),
        .right_data (right_data),
        .right_vld  (right_vld),
        .tick       (tick),
        .new_left   (new_left),
        .pos_nx     (pos_nx),
        .side_nx    (side_nx),
        .sdata      (sdata)
    );
endmodule

// File: tb/stereo_ser_tx_test.sv
module stereo_ser_tx_test;
    localparam int DIV = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_master = 1'b1, cfg_rjust = 1'b0, cfg_msb_dly = 1'b0;
    logic [15:0] left_data = '0, right_data = '0;
    logic left_vld = 1'b0, right_vld = 1'b0;
    logic bclk_i = 1'b1, lrck_i = 1'b1;
    logic bclk_o, lrck_o, sdata;

    int nvec = 0;
    int nfail = 0;
    logic rec_d [0:63];
    logic rec_l [0:63];
    bit   tim_bad;
    bit   pre_bad;

    always #2 clk = ~clk;

    stereo_ser_tx #(.WORD_W(16), .HALF_SLOTS(32), .DIV(DIV)) uut (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_rjust(cfg_rjust),
        .cfg_msb_dly(cfg_msb_dly), .left_data(left_data), .left_vld(left_vld),
        .right_data(right_data), .right_vld(right_vld), .bclk_i(bclk_i),
        .lrck_i(lrck_i), .bclk_o(bclk_o), .lrck_o(lrck_o), .sdata(sdata)
    );

    // cfg {master, rjust, msb_dly}, left word, right word
    localparam logic [34:0] VEC [0:7] = '{
        {3'b100, 16'h8000, 16'h7FFF},
        {3'b101, 16'hA5C3, 16'h0001},
        {3'b110, 16'hFFFF, 16'h1234},
        {3'b111, 16'h00FF, 16'hFF00},
        {3'b000, 16'h1357, 16'h8001},
        {3'b001, 16'h7FFF, 16'h8000},
        {3'b010, 16'hC0DE, 16'h0F0F},
        {3'b101, 16'h0000, 16'hFFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_half(input logic [15:0] w, input bit rj, input bit dl);
        int first;
        logic [31:0] e;
        first = rj ? 16 : (dl ? 1 : 0);
        e = '0;
        for (int p = 0; p < 32; p++)
            if (p >= first && p < first + 16) e[p] = w[15 - (p - first)];
        return e;
    endfunction

    function automatic logic [31:0] got_half(input int base);
        logic [31:0] g;
        for (int p = 0; p < 32; p++) g[p] = rec_d[base + p];
        return g;
    endfunction

    function automatic logic [31:0] lr_half(input int base);
        logic [31:0] g;
        for (int p = 0; p < 32; p++) g[p] = rec_l[base + p];
        return g;
    endfunction

    task automatic do_reset(input bit m, input bit rj, input bit dl);
        @(negedge clk);
        rst = 1'b1; cfg_master = m; cfg_rjust = rj; cfg_msb_dly = dl;
        bclk_i = 1'b1; lrck_i = 1'b1; left_vld = 1'b0; right_vld = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic release_load(input logic [15:0] l, input logic [15:0] r);
        rst = 1'b0; left_data = l; right_data = r; left_vld = 1'b1; right_vld = 1'b1;
        @(negedge clk);
        left_vld = 1'b0; right_vld = 1'b0;
    endtask

    task automatic collect_master(input int inj, input logic [15:0] il, input logic [15:0] ir);
        int n = 0, cyc = 0, last = -1;
        logic pb, pl, pd;
        pb = bclk_o; pl = lrck_o; pd = sdata;
        while (n < 64) begin
            @(negedge clk);
            cyc++;
            left_vld = 1'b0; right_vld = 1'b0;
            if (pb && !bclk_o) begin
                if (last >= 0 && cyc - last != 2 * DIV) tim_bad = 1'b1;
                last = cyc;
                rec_d[n] = sdata; rec_l[n] = lrck_o;
                if (n == inj) begin
                    left_data = il; right_data = ir; left_vld = 1'b1; right_vld = 1'b1;
                end
                n++;
            end else if (lrck_o != pl || sdata != pd) begin
                tim_bad = 1'b1;
            end
            pb = bclk_o; pl = lrck_o; pd = sdata;
        end
    endtask

    task automatic collect_slave(input int pre);
        @(negedge clk);
        for (int s = 0; s < pre + 64; s++) begin
            lrck_i = (s < pre) ? 1'b1 : ((s - pre) >= 32);
            bclk_i = 1'b0;
            repeat (3) @(negedge clk);
            if (s < pre) begin
                if (sdata !== 1'b0) pre_bad = 1'b1;
            end else begin
                rec_d[s - pre] = sdata;
                rec_l[s - pre] = lrck_i;
            end
            bclk_i = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        string tag;
        // R9: state held in reset
        do_reset(1'b1, 1'b0, 1'b0);
        chk("R9 sdata in reset", {31'd0, sdata}, 32'd0);
        chk("R9 bclk_o in reset", {31'd0, bclk_o}, 32'd0);
        chk("R9 lrck_o in reset", {31'd0, lrck_o}, 32'd1);

        // table walk: R1 R2 R3 placement, R4 channel order, R5/R7 clocking
        for (int v = 0; v < 8; v++) begin
            logic [34:0] e;
            bit m, rj, dl;
            e = VEC[v];
            m = e[34]; rj = e[33]; dl = e[32];
            tag = rj ? "R3" : (dl ? "R2" : "R1");
            do_reset(m, rj, dl);
            tim_bad = 1'b0;
            release_load(e[31:16], e[15:0]);
            if (m) collect_master(-1, 16'h0, 16'h0);
            else   collect_slave(0);
            chk({tag, " R4 left half"}, got_half(0), exp_half(e[31:16], rj, dl));
            chk({tag, " R4 right half"}, got_half(32), exp_half(e[15:0], rj, dl));
            if (m) begin
                chk("R4 frame clock per half", {lr_half(0) == 32'd0, lr_half(32) == '1},
                    {1'b1, 1'b1});
                chk("R5 R6 bit clock timing", {31'd0, tim_bad}, 32'd0);
            end
        end

        // R8: sample strobed mid-frame waits for the next frame
        do_reset(1'b1, 1'b0, 1'b0);
        release_load(16'h1111, 16'h2222);
        collect_master(5, 16'hBEEF, 16'hCAFE);
        chk("R8 current left kept", got_half(0), exp_half(16'h1111, 0, 0));
        chk("R8 current right kept", got_half(32), exp_half(16'h2222, 0, 0));
        collect_master(-1, 16'h0, 16'h0);
        chk("R8 next left", got_half(0), exp_half(16'hBEEF, 0, 0));
        chk("R8 next right", got_half(32), exp_half(16'hCAFE, 0, 0));

        // R7: slave starts during a right half
        do_reset(1'b0, 1'b0, 1'b1);
        pre_bad = 1'b0;
        release_load(16'h9876, 16'h0123);
        collect_slave(5);
        chk("R7 partial right half low", {31'd0, pre_bad}, 32'd0);
        chk("R7 R2 left after partial", got_half(0), exp_half(16'h9876, 0, 1));
        chk("R7 R2 right after partial", got_half(32), exp_half(16'h0123, 0, 1));

        // R9: reset in mid-frame, restart on left
        do_reset(1'b1, 1'b0, 1'b0);
        release_load(16'hFFFF, 16'hFFFF);
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 sdata low after reset edge", {31'd0, sdata}, 32'd0);
        repeat (2) @(negedge clk);
        release_load(16'h4321, 16'h8765);
        begin
            int cyc = 1;
            while (!(bclk_o === 1'b0 && cyc > 1 && lrck_o === 1'b0)) begin
                @(negedge clk);
                cyc++;
            end
            chk("R9 first fall delay", cyc, 2 * DIV);
        end
        do_reset(1'b1, 1'b0, 1'b0);
        release_load(16'h4321, 16'h8765);
        collect_master(-1, 16'h0, 16'h0);
        chk("R9 R4 left first after reset", got_half(0), exp_half(16'h4321, 0, 0));

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule